// File: doc/BRIEF.md
# Three-Tier Interrupt Controller

The block takes a set of level-sensitive request lines from peripherals and sorts each enabled request into one of three tiers. Sources placed in the fast class drive a dedicated fast-interrupt output. All other enabled sources drive the normal-interrupt output. Within the normal class, sixteen programmable slots each bind one source number to a handler address. Any other normal source is non-vectored and shares one default handler address.

Software programs the controller through a simple word-addressed register port. One register enables sources bit by bit, and a separate register clears them. A class register moves sources into the fast tier. Per-slot control and address registers set up the vectored tier. When the processor takes a normal interrupt, it reads the vector register to find the handler. That read freezes the returned address until software writes the acknowledge register. Status registers show the raw request lines, the pending fast-class sources and the pending normal-class sources, so a shared handler can identify its source.

Top module: `irq_tier_ctrl`

## Requirements
- R1: After reset, every source is disabled and in the normal class, every slot is disabled, the default address and the vector register read 0, and both interrupt outputs are low.
- R2: A write to the set-enable register (word 0x04) sets the enable bits written as 1. A write to the clear-enable register (word 0x05) clears the bits written as 1. Bits written as 0 are left unchanged. Reading word 0x04 returns the enable mask.
- R3: The raw status register (word 0x02) returns the request lines with no masking. The normal status register (word 0x00) returns request AND enable AND NOT fast-class.
- R4: The fast status register (word 0x01) returns request AND enable AND fast-class. The fast-interrupt output is the OR of those bits and follows the inputs with one clock of delay. The class register is word 0x03, where 1 means fast.
- R5: The normal-interrupt output is the OR of the normal status bits and follows the inputs with one clock of delay.
- R6: A source in the fast class takes no part in the normal output or in vector selection, even when a slot names it.
- R7: Slot n has a control word at 0x10+n and an address word at 0x20+n. In the control word, bit 5 is the enable and bits 4:0 are the source number. The vector register (word 0x06) returns the address of the lowest-numbered enabled slot whose source is set in the normal status.
- R8: A disabled slot never wins. When no slot wins, the vector register returns the default address (word 0x08).
- R9: A read of the vector register freezes the value it returned. Later reads return that same value until any write to the acknowledge register (word 0x07). From the next read after the acknowledge, the vector again follows arbitration.
- R10: Read data appears on the read-data port one clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req_i | input | 32 | Level request lines, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Normal-interrupt output to the processor |
| fiq_o | output | 1 | Fast-interrupt output to the processor |

## Verification
A request or configuration change made at a falling edge appears on both interrupt outputs and in the internal vector holding register at the next rising edge. The bench therefore samples one full clock later, at the following falling edge. A register read strobed at a falling edge returns its data at the next rising edge, and the bench samples that data at the falling edge after it. After an acknowledge write, the bench issues the next vector read immediately, because the holding register reloads at the acknowledge edge. Request lines are held steady during every status and vector read, so each expected value depends only on the configuration model and the current request word.

// File: rtl/irq_tier_pkg.sv
// Package: shared register offsets for the three-tier interrupt controller.
// Assumes a word-addressed register port with 8 address bits.
package irq_tier_pkg;
    localparam int REG_AW = 8;
    localparam logic [REG_AW-1:0] OFS_NORM_STAT = 8'h00;
    localparam logic [REG_AW-1:0] OFS_FAST_STAT = 8'h01;
    localparam logic [REG_AW-1:0] OFS_RAW_STAT  = 8'h02;
    localparam logic [REG_AW-1:0] OFS_CLASS     = 8'h03;
    localparam logic [REG_AW-1:0] OFS_EN_SET    = 8'h04;
    localparam logic [REG_AW-1:0] OFS_EN_CLR    = 8'h05;
    localparam logic [REG_AW-1:0] OFS_VECTOR    = 8'h06;
    localparam logic [REG_AW-1:0] OFS_ACK       = 8'h07;
    localparam logic [REG_AW-1:0] OFS_DEFAULT   = 8'h08;
    localparam logic [REG_AW-1:0] OFS_SLOT_CTL  = 8'h10;
    localparam logic [REG_AW-1:0] OFS_SLOT_ADR  = 8'h20;
endpackage

// File: rtl/irq_cfg_regs.sv
// Module: configuration register bank. It holds the enable mask, the class
// select, the default address and the per-slot control and address words.
// Assumes DATA_W >= NUM_SRC and NUM_SLOT <= 16, so that the slot windows
// do not overlap.
module irq_cfg_regs
    import irq_tier_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16,
    parameter int DATA_W   = 32,
    parameter int SRC_W    = $clog2(NUM_SRC)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [REG_AW-1:0]                 addr,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [NUM_SRC-1:0]                en_q,
    output logic [NUM_SRC-1:0]                fast_q,
    output logic [DATA_W-1:0]                 def_addr_q,
    output logic [NUM_SLOT-1:0]               slot_en_q,
    output logic [NUM_SLOT-1:0][SRC_W-1:0]    slot_src_q,
    output logic [NUM_SLOT-1:0][DATA_W-1:0]   slot_addr_q
);

    logic [NUM_SRC-1:0] wbits;
    assign wbits = wdata[NUM_SRC-1:0];

    // Enable mask: bits written as 1 are set or cleared; bits written as 0 stay.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (we && addr == OFS_EN_SET)
            en_q <= en_q | wbits;
        else if (we && addr == OFS_EN_CLR)
            en_q <= en_q & ~wbits;
    end

    // Class select and default handler address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q     <= '0;
            def_addr_q <= '0;
        end else if (we) begin
            if (addr == OFS_CLASS)   fast_q     <= wbits;
            if (addr == OFS_DEFAULT) def_addr_q <= wdata;
        end
    end

    // One control word and one address word per vectored slot.
    for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
        localparam logic [REG_AW-1:0] CTL_A = OFS_SLOT_CTL + REG_AW'(k);
        localparam logic [REG_AW-1:0] ADR_A = OFS_SLOT_ADR + REG_AW'(k);
        // Slot k write decode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_en_q[k]   <= 1'b0;
                slot_src_q[k]  <= '0;
                slot_addr_q[k] <= '0;
            end else if (we) begin
                if (addr == CTL_A) begin
                    slot_en_q[k]  <= wdata[SRC_W];
                    slot_src_q[k] <= wdata[SRC_W-1:0];
                end
                if (addr == ADR_A) slot_addr_q[k] <= wdata;
            end
        end
    end

    // R2: a set-enable write leaves every written-1 bit set.
    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_EN_SET) |=> ((en_q & $past(wbits)) == $past(wbits)));
    // R2: a clear-enable write leaves every written-1 bit cleared.
    assert_en_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_EN_CLR) |=> ((en_q & $past(wbits)) == '0));

endmodule

// File: rtl/irq_slot_pick.sv
// Module: vectored slot arbiter. A slot is a candidate when it is enabled and
// its selected source is pending in the normal class. The lowest index wins.
// Assumes pend already excludes disabled and fast-class sources.
module irq_slot_pick #(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16,
    parameter int SRC_W    = $clog2(NUM_SRC),
    parameter int SLOT_W   = $clog2(NUM_SLOT)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_SRC-1:0]             pend,
    input  logic [NUM_SLOT-1:0]            slot_en,
    input  logic [NUM_SLOT-1:0][SRC_W-1:0] slot_src,
    output logic                           hit,
    output logic [SLOT_W-1:0]              idx
);

    logic [NUM_SLOT-1:0] cand;

    for (genvar k = 0; k < NUM_SLOT; k++) begin : g_cand
        assign cand[k] = slot_en[k] & pend[slot_src[k]];
    end

    // Priority scan: the last assignment made is from the lowest candidate index.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = NUM_SLOT - 1; k >= 0; k--) begin
            if (cand[k]) begin
                hit = 1'b1;
                idx = SLOT_W'(k);
            end
        end
    end

    // R7: the winner is enabled and its source is pending.
    assert_win_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (slot_en[idx] && pend[slot_src[idx]]));
    // R8: no winner only when no enabled slot has a pending source.
    assert_no_win_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (cand == '0));
    // R7: no lower-numbered slot is also a candidate.
    assert_lowest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((cand & ((NUM_SLOT'(1) << idx) - NUM_SLOT'(1))) == '0));

endmodule

// File: rtl/irq_tier_ctrl.sv
// Module: top of the three-tier interrupt controller. It masks the requests,
// splits them into fast and normal classes, drives the two registered
// interrupt outputs, holds the vector register with freeze-until-acknowledge
// behaviour, and serves register reads with one clock of latency.
// Assumes level requests that are already synchronous to clk.
module irq_tier_ctrl
    import irq_tier_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_SLOT = 16,
    parameter int DATA_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic               reg_we,
    input  logic               reg_re,
    input  logic [REG_AW-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq_o,
    output logic               fiq_o
);

    localparam int SRC_W  = $clog2(NUM_SRC);
    localparam int SLOT_W = $clog2(NUM_SLOT);

    logic [NUM_SRC-1:0]              en_q, fast_q, norm_pend, fast_pend;
    logic [DATA_W-1:0]               def_addr_q, next_vec, vec_q, rd_mux;
    logic [NUM_SLOT-1:0]             slot_en_q;
    logic [NUM_SLOT-1:0][SRC_W-1:0]  slot_src_q;
    logic [NUM_SLOT-1:0][DATA_W-1:0] slot_addr_q;
    logic                            hit, rd_vec, ack_wr, in_service;
    logic [SLOT_W-1:0]               win_idx;

    irq_cfg_regs #(
        .NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .DATA_W(DATA_W), .SRC_W(SRC_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .en_q(en_q), .fast_q(fast_q), .def_addr_q(def_addr_q),
        .slot_en_q(slot_en_q), .slot_src_q(slot_src_q), .slot_addr_q(slot_addr_q)
    );

    assign norm_pend = irq_req_i & en_q & ~fast_q;
    assign fast_pend = irq_req_i & en_q & fast_q;

    irq_slot_pick #(
        .NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .SRC_W(SRC_W), .SLOT_W(SLOT_W)
    ) u_pick (
        .clk(clk), .rst_n(rst_n), .pend(norm_pend), .slot_en(slot_en_q),
        .slot_src(slot_src_q), .hit(hit), .idx(win_idx)
    );

    assign next_vec = hit ? slot_addr_q[win_idx] : def_addr_q;
    assign rd_vec   = reg_re && (reg_addr == OFS_VECTOR);
    assign ack_wr   = reg_we && (reg_addr == OFS_ACK);

    // Registered interrupt outputs to the processor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= |norm_pend;
            fiq_o <= |fast_pend;
        end
    end

    // Service flag: set by a vector read, cleared by an acknowledge write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_service <= 1'b0;
        else if (ack_wr)
            in_service <= 1'b0;
        else if (rd_vec)
            in_service <= 1'b1;
    end

    // Vector holding register: tracks arbitration unless frozen by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vec_q <= '0;
        else if (ack_wr || (!in_service && !rd_vec))
            vec_q <= next_vec;
    end

    // Read multiplexer over status, configuration and slot words.
    always_comb begin
        rd_mux = '0;
        case (reg_addr)
            OFS_NORM_STAT: rd_mux = DATA_W'(norm_pend);
            OFS_FAST_STAT: rd_mux = DATA_W'(fast_pend);
            OFS_RAW_STAT:  rd_mux = DATA_W'(irq_req_i);
            OFS_CLASS:     rd_mux = DATA_W'(fast_q);
            OFS_EN_SET:    rd_mux = DATA_W'(en_q);
            OFS_VECTOR:    rd_mux = vec_q;
            OFS_DEFAULT:   rd_mux = def_addr_q;
            default:       rd_mux = '0;
        endcase
        for (int k = 0; k < NUM_SLOT; k++) begin
            if (reg_addr == OFS_SLOT_CTL + REG_AW'(k))
                rd_mux = DATA_W'({slot_en_q[k], slot_src_q[k]});
            if (reg_addr == OFS_SLOT_ADR + REG_AW'(k))
                rd_mux = slot_addr_q[k];
        end
    end

    // Read data register, loaded on a read strobe only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_re)
            reg_rdata <= rd_mux;
    end

    // R5 and R6: the normal output rises only for an enabled normal-class request.
    assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(irq_req_i & en_q & ~fast_q)));
    // R4: the fast output follows the enabled fast-class requests one clock later.
    assert_fiq_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(|(irq_req_i & en_q & fast_q)) |-> fiq_o);
    // R9: while frozen, and with no acknowledge, the vector holds.
    assert_vec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((in_service || rd_vec) && !ack_wr) |=> $stable(vec_q));
    // R10: read data changes only after a read strobe.
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> $stable(reg_rdata));

endmodule

// File: tb/tb_irq_tier_ctrl.sv
// Bench: directed corner cases and seeded random traffic, checked against a
// configuration model kept in the bench.
module tb_irq_tier_ctrl;
    localparam int NS = 32;
    localparam int NSL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o, fiq_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] m_en = '0, m_fast = '0, m_def = '0;
    logic [NSL-1:0] m_sen = '0;
    logic [4:0]  m_src [NSL];
    logic [31:0] m_adr [NSL];

    irq_tier_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_req_i(req), .reg_we(we), .reg_re(re),
        .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] f_norm();
        return req & m_en & ~m_fast;
    endfunction

    function automatic logic [31:0] f_fast();
        return req & m_en & m_fast;
    endfunction

    function automatic logic [31:0] f_vec();
        logic [31:0] np = f_norm();
        for (int k = 0; k < NSL; k++)
            if (m_sen[k] && np[m_src[k]]) return m_adr[k];
        return m_def;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        re = 1'b1; addr = a;
        @(posedge clk);
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic set_slot(int k, bit en, logic [4:0] src, logic [31:0] adr);
        wr(8'h10 + 8'(k), {26'b0, en, src});
        wr(8'h20 + 8'(k), adr);
        m_sen[k] = en; m_src[k] = src; m_adr[k] = adr;
    endtask

    // Drive requests at a falling edge and wait one full clock for the outputs.
    task automatic apply_req(logic [31:0] r);
        @(negedge clk);
        req = r;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(string ctx);
        logic [31:0] d;
        chk({ctx, " R5 irq_o"}, 32'(irq_o), 32'(|f_norm()));
        chk({ctx, " R4 fiq_o"}, 32'(fiq_o), 32'(|f_fast()));
        rd(8'h00, d); chk({ctx, " R3 normal status"}, d, f_norm());
        rd(8'h01, d); chk({ctx, " R4 fast status"}, d, f_fast());
        rd(8'h02, d); chk({ctx, " R3 raw status"}, d, req);
        rd(8'h06, d); chk({ctx, " R7 vector"}, d, f_vec());
        wr(8'h07, 32'h0);
    endtask

    initial begin
        logic [31:0] d, held;
        for (int k = 0; k < NSL; k++) begin m_src[k] = '0; m_adr[k] = '0; end
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        chk("R1 irq_o", 32'(irq_o), 0);
        chk("R1 fiq_o", 32'(fiq_o), 0);
        rd(8'h04, d); chk("R1 enable", d, 0);
        rd(8'h03, d); chk("R1 class", d, 0);
        rd(8'h06, d); chk("R1 vector", d, 0);
        wr(8'h07, 0);
        rd(8'h10, d); chk("R1 slot0 ctl", d, 0);

        // R2: set and clear enable registers.
        wr(8'h04, 32'h0000_F0F0);
        wr(8'h04, 32'h0000_000F);
        rd(8'h04, d); chk("R2 set accumulates", d, 32'h0000_F0FF);
        wr(8'h05, 32'h0000_00F0);
        rd(8'h04, d); chk("R2 clear", d, 32'h0000_F00F);
        wr(8'h05, 32'h0);
        rd(8'h04, d); chk("R2 zero clear no effect", d, 32'h0000_F00F);
        wr(8'h05, 32'hFFFF_FFFF);
        m_en = '0;

        // R7/R8: slot priority, disabled slots and the default address.
        wr(8'h08, 32'hDEF0_0000); m_def = 32'hDEF0_0000;
        wr(8'h04, 32'hFFFF_FFFF); m_en = '1;
        set_slot(3, 1, 5'd5, 32'h0000_3300);
        set_slot(7, 1, 5'd9, 32'h0000_7700);
        apply_req(32'h0000_0220);
        rd(8'h06, d); chk("R7 lower slot wins", d, 32'h0000_3300);
        wr(8'h07, 0);
        set_slot(3, 0, 5'd5, 32'h0000_3300);
        apply_req(32'h0000_0220);
        rd(8'h06, d); chk("R8 disabled slot skipped", d, 32'h0000_7700);
        wr(8'h07, 0);
        // R6: source 9 moved to the fast class.
        wr(8'h03, 32'h0000_0200); m_fast = 32'h0000_0200;
        apply_req(32'h0000_0200);
        chk("R6 irq_o low for fast source", 32'(irq_o), 0);
        chk("R4 fiq_o high", 32'(fiq_o), 1);
        rd(8'h06, d); chk("R6 R8 default vector", d, 32'hDEF0_0000);
        wr(8'h07, 0);
        apply_req(32'h0000_0220);
        rd(8'h06, d); chk("R8 non-vectored default", d, 32'hDEF0_0000);
        chk("R5 irq_o high", 32'(irq_o), 1);
        wr(8'h07, 0);

        // R9: freeze on read, release on acknowledge.
        wr(8'h03, 0); m_fast = '0;
        apply_req(32'h0000_0200);
        rd(8'h06, held); chk("R9 first read", held, 32'h0000_7700);
        apply_req(32'h0);
        rd(8'h06, d); chk("R9 frozen after request drop", d, held);
        rd(8'h00, d); chk("R10 status read", d, 0);
        wr(8'h07, 0);
        rd(8'h06, d); chk("R9 released after ack", d, 32'hDEF0_0000);
        wr(8'h07, 0);

        // Random traffic.
        for (int it = 0; it < 300; it++) begin
            if ($urandom_range(0, 3) == 0)
                set_slot($urandom_range(0, NSL - 1), 1'($urandom_range(0, 3) != 0),
                         5'($urandom), $urandom);
            if ($urandom_range(0, 3) == 0) begin
                d = $urandom; wr(8'h04, d); m_en = m_en | d;
            end
            if ($urandom_range(0, 3) == 0) begin
                d = $urandom & $urandom; wr(8'h05, d); m_en = m_en & ~d;
            end
            if ($urandom_range(0, 5) == 0) begin
                d = $urandom & $urandom & $urandom; wr(8'h03, d); m_fast = d;
            end
            if ($urandom_range(0, 9) == 0) begin
                d = $urandom; wr(8'h08, d); m_def = d;
            end
            apply_req(($urandom_range(0, 1) != 0) ? ($urandom & $urandom & $urandom) : $urandom);
            check_all("rand");
        end
        rd(8'h04, d); chk("R2 final enable", d, m_en);

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule